// File: doc/BRIEF.md
# Telegram Receive Synchronization Controller

This block sits behind a serial slave receiver. It decides whether a finished telegram is valid, issues a one-cycle receive strobe for each accepted telegram, and keeps track of whether the receiver is locked to the bus. Bit decoding, pause timing and answer formatting are done elsewhere. Their results arrive here as a frame-complete pulse, a vector of frame error flags, a line-pause indication and the decoded slave address.

If any error flag is raised when a telegram completes, the telegram is rejected and the block falls out of sync. It then discards every further telegram until the pause detector reports a quiet line. After that pause, the next clean telegram is accepted and the block is synchronized again. A telegram that carries this slave's address also turns on the transmitter enable early, so that the line driver can settle before the answer starts. The enable stays on until the answer is reported finished.

Top module: `rx_sync_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_strobe`, `in_sync` and `tx_en` are 0. The block starts out of sync and has not yet seen a pause.
- R2: A `frame_done` pulse with all error flags clear, sampled while the block accepts telegrams, produces `rx_strobe` high for exactly one cycle, starting one clock after the sampling edge.
- R3: If any bit of `frame_err` is 1 when `frame_done` is sampled, no strobe is produced and `in_sync` is 0 after that edge. The bits are [0] start bit, [1] coding, [2] parity, [3] end bit, [4] length.
- R4: While out of sync with no pause seen yet, a completed telegram is discarded even if it has no error. `rx_strobe` stays 0, `in_sync` stays 0, and `tx_en` does not change.
- R5: A `line_pause` sampled while waiting makes the block ready. The next clean telegram then raises `rx_strobe` and `in_sync` on the same edge.
- R6: `line_pause` has no effect while the block is synchronized.
- R7: `tx_en` rises one cycle after a strobe whose telegram had `rx_addr == own_addr` at the `frame_done` edge. A strobe for any other address leaves `tx_en` unchanged.
- R8: `answer_done` clears `tx_en` on the next edge. A frame error does not clear it. When a strobe for this slave coincides with `answer_done`, the set wins.
- R9: If `frame_done` and `line_pause` are sampled on the same edge while waiting, the telegram is discarded and the pause is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse when a telegram has been fully received |
| frame_err | input | ERR_W (5) | Frame error flags, valid with `frame_done` |
| line_pause | input | 1 | Pulse or level from the pause detector |
| rx_addr | input | ADDR_W (5) | Decoded slave address of the current telegram |
| own_addr | input | ADDR_W (5) | Stored address of this slave |
| answer_done | input | 1 | Pulse when the slave answer has been sent |
| rx_strobe | output | 1 | One-cycle receive strobe for a valid telegram |
| in_sync | output | 1 | 1 when synchronized, 0 when out of sync |
| tx_en | output | 1 | Transmitter enable |

## Verification
`rx_strobe` and `in_sync` come from registers fed straight by the inputs. They are therefore due one clock after the edge that samples `frame_done` or `line_pause`. `tx_en` has one more register behind the strobe, so it is due two clocks after `frame_done` and one clock after `answer_done`. The bench drives each vector just after a falling edge and compares all three outputs at the following falling edge. The expected `tx_en` column in the table already accounts for this extra cycle of lag.

// File: rtl/rxs_pkg.sv
// Package: shared types for the receive synchronization controller.
// Assumes: three legal receive states; any other encoding is illegal.
package rxs_pkg;
    typedef enum logic [1:0] {
        RXS_WAIT  = 2'b00,  // out of sync, waiting for a line pause
        RXS_READY = 2'b01,  // out of sync, pause seen, next telegram accepted
        RXS_SYNC  = 2'b10   // synchronized
    } rxs_state_t;
endpackage

// File: rtl/rxs_err_merge.sv
// Module: merges the per-cause frame error flags into one flag.
// Assumes: flags are valid in the cycle frame_done is high.
module rxs_err_merge #(
    parameter int ERR_W = 5
) (
    input  logic [ERR_W-1:0] err_in,
    output logic             any_err
);
    logic [ERR_W:0] chain;

    assign chain[0] = 1'b0;
    generate
        for (genvar i = 0; i < ERR_W; i++) begin : g_or
            assign chain[i+1] = chain[i] | err_in[i];
        end
    endgenerate
    assign any_err = chain[ERR_W];
endmodule

// File: rtl/rxs_sync_fsm.sv
// Module: synchronization state machine and receive strobe register.
// Assumes: frame_done is a single-cycle pulse; illegal states fall back to WAIT.
module rxs_sync_fsm
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done,
    input  logic       any_err,
    input  logic       line_pause,
    output logic       strobe,
    output logic       sync_flag,
    output rxs_state_t state
);
    rxs_state_t nxt;
    logic       accept;

    assign accept = (state == RXS_READY) || (state == RXS_SYNC);

    // Next-state decision from the current state, telegram and pause.
    always_comb begin
        nxt = state;
        case (state)
            RXS_WAIT:  if (line_pause) nxt = RXS_READY;
            RXS_READY: if (frame_done) nxt = any_err ? RXS_WAIT : RXS_SYNC;
            RXS_SYNC:  if (frame_done && any_err) nxt = RXS_WAIT;
            default:   nxt = RXS_WAIT;
        endcase
    end

    // State, strobe and sync flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RXS_WAIT;
            strobe    <= 1'b0;
            sync_flag <= 1'b0;
        end else begin
            state     <= nxt;
            strobe    <= frame_done && !any_err && accept;
            sync_flag <= (nxt == RXS_SYNC);
        end
    end
endmodule

// File: rtl/rxs_tx_gate.sv
// Module: transmitter enable control; the strobe of a telegram for this
// slave switches the enable on, a finished answer switches it off.
// Assumes: rx_addr is valid in the cycle frame_done is high.
module rxs_tx_gate #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              strobe,
    input  logic              answer_done,
    output logic              tx_en
);
    logic hit_q;

    // Address match captured alongside the telegram end.
    always_ff @(posedge clk) begin
        if (!rst_n)          hit_q <= 1'b0;
        else if (frame_done) hit_q <= (rx_addr == own_addr);
    end

    // Enable register: a set from the strobe wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               tx_en <= 1'b0;
        else if (strobe && hit_q) tx_en <= 1'b1;
        else if (answer_done)     tx_en <= 1'b0;
    end
endmodule

// File: rtl/rx_sync_ctrl.sv
// Module: top of the telegram receive synchronization controller.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module rx_sync_ctrl #(
    parameter int ERR_W  = 5,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [ERR_W-1:0]  frame_err,
    input  logic              line_pause,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              answer_done,
    output logic              rx_strobe,
    output logic              in_sync,
    output logic              tx_en
);
    import rxs_pkg::*;

    logic       any_err;
    rxs_state_t cur_st;

    rxs_err_merge #(.ERR_W(ERR_W)) u_err (
        .err_in  (frame_err),
        .any_err (any_err)
    );

    rxs_sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .any_err    (any_err),
        .line_pause (line_pause),
        .strobe     (rx_strobe),
        .sync_flag  (in_sync),
        .state      (cur_st)
    );

    rxs_tx_gate #(.ADDR_W(ADDR_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .rx_addr     (rx_addr),
        .own_addr    (own_addr),
        .strobe      (rx_strobe),
        .answer_done (answer_done),
        .tx_en       (tx_en)
    );
endmodule

// File: rtl/rx_sync_ctrl_chk.sv
// Module: assertion checker for rx_sync_ctrl, attached by bind.
// Assumes: the bound design uses the state encoding of rxs_pkg.
module rx_sync_ctrl_chk #(
    parameter int ERR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_done,
    input logic [ERR_W-1:0] frame_err,
    input logic             answer_done,
    input logic             rx_strobe,
    input logic             in_sync,
    input logic             tx_en,
    input logic [1:0]       st
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rx_strobe && !in_sync && !tx_en));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R3
    err_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && (frame_err != '0)) |=> (!rx_strobe && !in_sync));

    // R4
    wait_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && st == 2'b00) |=> !rx_strobe);

    // R5
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> rx_strobe);

    // R7
    tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(rx_strobe));

    // R8
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (answer_done && !rx_strobe) |=> !tx_en);
endmodule

bind rx_sync_ctrl rx_sync_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .frame_err   (frame_err),
    .answer_done (answer_done),
    .rx_strobe   (rx_strobe),
    .in_sync     (in_sync),
    .tx_en       (tx_en),
    .st          (cur_st)
);

// File: tb/test_rx_sync_ctrl.sv
module test_rx_sync_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0;
    logic [4:0] frame_err = '0;
    logic       line_pause = 1'b0;
    logic [4:0] rx_addr = '0;
    logic [4:0] own_addr = 5'd9;
    logic       answer_done = 1'b0;
    logic       rx_strobe, in_sync, tx_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sync_ctrl i_rx_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_err(frame_err),
        .line_pause(line_pause), .rx_addr(rx_addr), .own_addr(own_addr),
        .answer_done(answer_done), .rx_strobe(rx_strobe), .in_sync(in_sync),
        .tx_en(tx_en)
    );

    // {frame_done, err[4:0], pause, addr[4:0], answer_done, exp_strobe, exp_sync, exp_tx}
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b000}, // 0  R4 discard before pause
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b000}, // 1  R5 pause
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b110}, // 2  R5 strobe + sync
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b0, 3'b011}, // 3  R7 tx on
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b1, 3'b010}, // 4  R8 tx off
        {1'b1, 5'b00000, 1'b0, 5'd3, 1'b0, 3'b110}, // 5  R2 other address
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b0, 3'b010}, // 6  R7 no tx
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b010}, // 7  R6 pause ignored
        {1'b1, 5'b00001, 1'b0, 5'd9, 1'b0, 3'b000}, // 8  R3 start bit
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b000}, // 9  R4 discard
        {1'b1, 5'b00000, 1'b1, 5'd9, 1'b0, 3'b000}, // 10 R9 same edge
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b110}, // 11 R9 pause accepted
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b0, 3'b011}, // 12 R7
        {1'b1, 5'b10000, 1'b0, 5'd9, 1'b0, 3'b001}, // 13 R3 length, R8 tx kept
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b1, 3'b000}, // 14 R8
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b000}, // 15 pause
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b110}, // 16 R2
        {1'b1, 5'b00100, 1'b0, 5'd9, 1'b0, 3'b001}, // 17 R3 parity, back to back
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b001}, // 18 pause
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b1, 3'b110}, // 19 R8 clear
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b1, 3'b011}, // 20 R8 set wins
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b1, 3'b010}, // 21 R8
        {1'b1, 5'b00010, 1'b0, 5'd9, 1'b0, 3'b000}, // 22 R3 coding
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b000}, // 23 pause
        {1'b1, 5'b01000, 1'b0, 5'd9, 1'b0, 3'b000}, // 24 R3 end bit while ready
        {1'b0, 5'b00000, 1'b1, 5'd0, 1'b0, 3'b000}, // 25 pause
        {1'b1, 5'b00000, 1'b0, 5'd9, 1'b0, 3'b110}, // 26 R5
        {1'b0, 5'b00000, 1'b0, 5'd0, 1'b0, 3'b011}  // 27 R7
    };

    task automatic check(input string req, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual %b expected %b", req, idx, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", -1, rx_strobe, 1'b0);
        check("R1", -1, in_sync, 1'b0);
        check("R1", -1, tx_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", -1, in_sync, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {frame_done, frame_err, line_pause, rx_addr, answer_done} = VEC[i][15:3];
            @(negedge clk);
            check("R2", i, rx_strobe, VEC[i][2]);
            check("R5", i, in_sync,   VEC[i][1]);
            check("R7", i, tx_en,     VEC[i][0]);
        end
        {frame_done, frame_err, line_pause, rx_addr, answer_done} = '0;

        // R1: reset while synchronized with the transmitter on
        check("R1", 100, tx_en, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 101, rx_strobe, 1'b0);
        check("R1", 101, in_sync, 1'b0);
        check("R1", 101, tx_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: after reset a clean telegram is discarded
        frame_done = 1'b1; rx_addr = 5'd9;
        @(negedge clk);
        frame_done = 1'b0;
        check("R4", 102, rx_strobe, 1'b0);
        @(negedge clk);
        check("R4", 103, tx_en, 1'b0);

        // R2: strobe lasts exactly one cycle
        line_pause = 1'b1;
        @(negedge clk);
        line_pause = 1'b0; frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check("R2", 104, rx_strobe, 1'b1);
        @(negedge clk);
        check("R2", 105, rx_strobe, 1'b0);
        check("R7", 105, tx_en, 1'b1);

        finish_run();
    end
endmodule